// File: doc/BRIEF.md
# I2C Target Engine for an 8-bit Port Expander

This block is the serial front end of an 8-bit port expander. It watches the two I2C bus lines from inside a fast system clock domain. Each line is passed through a two-flop synchronizer and a glitch filter before anything uses it. From the cleaned lines the engine finds start, repeated start and stop conditions. It answers one 7-bit address, whose upper four bits are fixed and whose lower three bits come from strap pins. It drives SDA only through a pull-low enable.

The first byte of any write to the engine is a command byte. Its two low bits pick one of four port registers: input (0), output (1), polarity (2) or configuration (3). That choice is held in a pointer register. The pointer is loaded only by a command byte and never steps on its own. Every later byte of the same write is handed to the selected register through a data bus and a one-cycle strobe. A read, whether after a stop or after a repeated start, shifts out the byte on the read-data input for the selected register. It repeats that byte for as long as the controller acknowledges.

The register file itself sits outside this block. It receives the select, the write data and the strobe, and it returns the read data. A per-byte read-acknowledge event lets neighbouring logic, such as an interrupt clear, tell when a read byte has been taken.

Top module: `pxio_i2c_target`

## Requirements
- R1: The engine acknowledges only the address byte 0,1,0,0,S2,S1,S0 followed by the R/W bit (MSB first, S = strap pins, R/W = 1 read, 0 write). For any other address it never pulls SDA and ignores the rest of the transfer until the next start.
- R2: Start (SDA falls, SCL high) and stop (SDA rises, SCL high) are detected at any point in a transfer. Either one releases SDA, and the engine alters its SDA drive only after a detected SCL falling edge or a start or stop.
- R3: The engine holds SDA low for the whole ninth clock after a matching address byte and after every byte it receives in a write.
- R4: The first byte after a write address loads the pointer from its bits [1:0], which appear on the register select. Bits [7:2] of that byte are ignored.
- R5: Each further byte of the same write produces one write strobe carrying that byte, with the register select unchanged. The byte count has no limit and there is no auto-increment.
- R6: The pointer keeps its value across stop and repeated start. A read returns the read data of the selected register, byte after byte.
- R7: During a read, the target shifts out the read data MSB first and reloads it after every controller ACK. After a NACK it lets go of SDA.
- R8: Each byte shifted out in a read produces exactly one read-acknowledge pulse, on the SCL rising edge of its acknowledge bit, whether the bit is ACK or NACK.
- R9: After reset the engine is idle, SDA is released, the pointer is 0 and no strobe is issued.
- R10: A level change on SCL or SDA lasting fewer than FILT_CNT system clocks has no effect on the transfer.
- R11: The strap pins are sampled at each start. Changes to them after the start do not affect address matching until the next start.
- R12: A write made up of an address and a command byte only changes the pointer and issues no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| strap_i | input | 3 | Low address bits from strap pins |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| reg_sel_o | output | 2 | Pointer: selected port register |
| wr_data_o | output | 8 | Byte written to the selected register |
| wr_stb_o | output | 1 | One-cycle write strobe for wr_data_o |
| rd_data_i | input | 8 | Contents of the selected register |
| rd_ack_o | output | 1 | One-cycle pulse at the acknowledge bit of each read byte |

## Verification
On every cycle the assertions check three timing rules. The SDA drive changes only after an SCL fall, a start or a stop. A start always leaves SDA released. Strobes and read-acknowledge pulses appear only right after the matching SCL edge. They also check that the pointer moves only when a command byte completes, and that the filtered line copies only a value it has already seen at the synchronizer. The behaviours that need whole transactions can only be shown by the bench scenarios. These are address rejection, strap latching at start, masking of the upper command bits, repeated reads of the same register across stops and repeated starts, the ACK/NACK read loop, and rejection of a short SCL glitch in the middle of a byte.

// File: rtl/pxio_pkg.sv
`timescale 1ns/100ps
package pxio_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int PTR_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WR_ACK,
    ST_RDATA,
    ST_RACK
  } xfer_state_t;
endpackage

// File: rtl/pxio_line_filter.sv
`timescale 1ns/100ps
// Two-flop synchronizer plus a run-length glitch filter for one bus line.
// The output follows the input only after FILT_CNT consecutive differing samples.
module pxio_line_filter #(
  parameter int FILT_CNT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_CNT < 2) ? 1 : $clog2(FILT_CNT);
  localparam logic [CW-1:0] LIM = CW'(FILT_CNT - 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == LIM) filt_d = sync_q[1];
      else              cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = filt_q;

  // R10: filtered level only ever takes a value already present at the synchronizer
  a_r10_filter_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q[1])));
endmodule

// File: rtl/pxio_bus_events.sv
`timescale 1ns/100ps
// Edge and bus-condition detection on the filtered lines.
module pxio_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/pxio_xfer_fsm.sv
`timescale 1ns/100ps
// Byte engine: address match, command pointer, write strobes, read shifting.
module pxio_xfer_fsm
  import pxio_pkg::*;
#(
  parameter int                STRAP_W   = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic [PTR_W-1:0]   reg_sel_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_stb_o,
  output logic               rd_ack_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  xfer_state_t        state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  wdat_q, wdat_d;
  logic [STRAP_W-1:0] strap_q, strap_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               rw_q, rw_d;
  logic               mack_q, mack_d;
  logic               pull_q, pull_d;
  logic               stb_q, stb_d;
  logic               rdack_q, rdack_d;
  logic [ADDR_W-1:0]  own_addr;

  assign own_addr = {ADDR_BASE[ADDR_W-1:STRAP_W], strap_q};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    wdat_d  = wdat_q;
    strap_d = strap_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    pull_d  = pull_q;
    stb_d   = 1'b0;
    rdack_d = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
      strap_d = strap_i;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + CNT_ONE;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            cnt_d  = '0;
            pull_d = 1'b1;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == own_addr) begin
                rw_d    = sh_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                pull_d  = 1'b0;
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              ptr_d   = sh_q[PTR_W-1:0];
              state_d = ST_CMD_ACK;
            end else begin
              wdat_d  = sh_q;
              stb_d   = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK: begin
          if (scl_rise_i) begin
            cnt_d = CNT_ONE;
          end else if (scl_fall_i && cnt_q != '0) begin
            cnt_d  = '0;
            pull_d = 1'b0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              sh_d    = rd_data_i;
              pull_d  = ~rd_data_i[BYTE_W-1];
              state_d = ST_RDATA;
            end else if (state_q == ST_ADDR_ACK) begin
              state_d = ST_CMD;
            end else begin
              state_d = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + CNT_ONE;
          end else if (scl_fall_i) begin
            if (cnt_q == CNT_FULL) begin
              cnt_d   = '0;
              pull_d  = 1'b0;
              state_d = ST_RACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            cnt_d   = CNT_ONE;
            mack_d  = ~sda_i;
            rdack_d = 1'b1;
          end else if (scl_fall_i && cnt_q != '0) begin
            cnt_d = '0;
            if (mack_q) begin
              sh_d    = rd_data_i;
              pull_d  = ~rd_data_i[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      wdat_q  <= '0;
      strap_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
      rdack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wdat_q  <= wdat_d;
      strap_q <= strap_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
      stb_q   <= stb_d;
      rdack_q <= rdack_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign reg_sel_o  = ptr_q;
  assign wr_data_o  = wdat_q;
  assign wr_stb_o   = stb_q;
  assign rd_ack_o   = rdack_q;

  // R2: SDA drive moves only after an SCL fall or a bus condition
  a_r2_pull_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_q != $past(pull_q)) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
  // R2: a start always leaves SDA released
  a_r2_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pull_q);
  // R4: pointer changes only when a command byte completes
  a_r4_ptr_from_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |-> $past(state_q == ST_CMD));
  // R5: write strobes follow an SCL falling edge
  a_r5_stb_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(scl_fall_i));
  // R8: read-acknowledge pulses follow an SCL rising edge
  a_r8_rdack_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(scl_rise_i));
endmodule

// File: rtl/pxio_i2c_target.sv
`timescale 1ns/100ps
module pxio_i2c_target
  import pxio_pkg::*;
#(
  parameter int                FILT_CNT  = 10,
  parameter int                STRAP_W   = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o,
  output logic [PTR_W-1:0]   reg_sel_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_stb_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               rd_ack_o
);
  localparam int NLINES = 2;
  localparam int SCL_IX = 0;
  localparam int SDA_IX = 1;

  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic [NLINES-1:0] raw_lines, filt_lines;
  logic              scl_rise, scl_fall, bus_start, bus_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  assign raw_lines[SCL_IX] = scl_i;
  assign raw_lines[SDA_IX] = sda_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    pxio_line_filter #(.FILT_CNT(FILT_CNT)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  pxio_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (filt_lines[SCL_IX]),
    .sda_i      (filt_lines[SDA_IX]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  pxio_xfer_fsm #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_i      (filt_lines[SDA_IX]),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data_i),
    .sda_pull_o (sda_pull_o),
    .reg_sel_o  (reg_sel_o),
    .wr_data_o  (wr_data_o),
    .wr_stb_o   (wr_stb_o),
    .rd_ack_o   (rd_ack_o)
  );
endmodule

// File: tb/pxio_i2c_target_tb_top.sv
`timescale 1ns/100ps
module pxio_i2c_target_tb_top;
  localparam int HP = 40;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull, wr_stb, rd_ack;
  logic [1:0] reg_sel;
  logic [7:0] wr_data, rd_data;
  logic [7:0] bank [4];
  logic [7:0] exp_bank [4];
  logic [9:0] exp_q [$];
  logic [9:0] exp_item;
  logic [1:0] model_sel = 2'd0;
  int n_chk = 0, n_fail = 0, n_stb = 0, n_rdack = 0;
  logic scl_line, sda_line;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m | scl_gl;
  assign sda_line = sda_m & ~sda_pull;
  assign rd_data  = bank[reg_sel];

  pxio_i2c_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull), .reg_sel_o(reg_sel),
    .wr_data_o(wr_data), .wr_stb_o(wr_stb), .rd_data_i(rd_data), .rd_ack_o(rd_ack)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items as strobes appear and models the register file
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      n_stb++;
      bank[reg_sel] = wr_data;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: actual unexpected strobe %0h expected none", {reg_sel, wr_data});
      end else begin
        exp_item = exp_q.pop_front();
        check_eq("R5 strobe sel/data", {22'd0, reg_sel, wr_data}, {22'd0, exp_item});
      end
    end
    if (rst_n && rd_ack) n_rdack++;
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        repeat (10) @(negedge clk);
        scl_gl = 1'b1;
        repeat (4) @(negedge clk);
        scl_gl = 1'b0;
      end
      hp(); scl_m = 1'b1; hp(); hp(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    acked = !sda_line;
    hp(); scl_m = 1'b0;
  endtask

  // Driver side of a written data byte: push expectation, then send
  task automatic put_data(input logic [7:0] b, input bit glitch, input string req);
    bit ak;
    exp_q.push_back({model_sel, b});
    exp_bank[model_sel] = b;
    put_byte(b, glitch, ak);
    check_eq(req, {31'd0, ak}, 32'd1);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1; hp(); b[i] = sda_line; hp(); scl_m = 1'b0;
    end
    sda_m = !give_ack; hp(); scl_m = 1'b1; hp(); hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] adr(input logic [2:0] s, input bit rd);
    return {4'b0100, s, rd};
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    bank[0] = 8'hA5; bank[1] = 8'h3C; bank[2] = 8'h96; bank[3] = 8'h0F;
    for (int i = 0; i < 4; i++) exp_bank[i] = bank[i];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R9 sda released", {31'd0, sda_pull}, 0);
    check_eq("R9 pointer cleared", {30'd0, reg_sel}, 0);
    check_eq("R9 no strobe", {31'd0, wr_stb}, 0);

    // Read with no command yet: pointer 0, two bytes
    i2c_start();
    check_eq("R2 released after start", {31'd0, sda_pull}, 0);
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    check_eq("R3 address ack (read)", {31'd0, ak}, 1);
    get_byte(1'b1, rb);
    check_eq("R9 read of register 0", {24'd0, rb}, {24'd0, exp_bank[0]});
    get_byte(1'b0, rb);
    check_eq("R7 repeated byte after ACK", {24'd0, rb}, {24'd0, exp_bank[0]});
    check_eq("R7 SDA released after NACK", {31'd0, sda_pull}, 0);
    i2c_stop();
    check_eq("R8 read ack pulses", n_rdack, 2);

    // Other address: no ACK, data ignored
    i2c_start();
    put_byte(adr(3'b100, 1'b0), 1'b0, ak);
    check_eq("R1 foreign address not acked", {31'd0, ak}, 0);
    put_byte(8'h01, 1'b0, ak);
    check_eq("R1 byte after foreign address not acked", {31'd0, ak}, 0);
    i2c_stop();
    check_eq("R1 pointer untouched", {30'd0, reg_sel}, 0);

    // Write: command with high bits set, three data bytes
    i2c_start();
    put_byte(adr(3'b101, 1'b0), 1'b0, ak);
    check_eq("R3 address ack (write)", {31'd0, ak}, 1);
    put_byte(8'hFD, 1'b0, ak);
    check_eq("R3 command ack", {31'd0, ak}, 1);
    model_sel = 2'd1;
    check_eq("R4 upper command bits ignored", {30'd0, reg_sel}, 1);
    put_data(8'h11, 1'b0, "R3 data ack 1");
    put_data(8'h22, 1'b0, "R3 data ack 2");
    put_data(8'h33, 1'b0, "R3 data ack 3");
    check_eq("R5 select unchanged after bytes", {30'd0, reg_sel}, 1);
    i2c_stop();
    check_eq("R6 pointer kept after stop", {30'd0, reg_sel}, 1);

    // Read after stop: same register, three bytes
    i2c_start();
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    get_byte(1'b1, rb);
    check_eq("R6 read after stop b0", {24'd0, rb}, {24'd0, exp_bank[1]});
    get_byte(1'b1, rb);
    check_eq("R7 read loop b1", {24'd0, rb}, {24'd0, exp_bank[1]});
    get_byte(1'b0, rb);
    check_eq("R7 read loop b2", {24'd0, rb}, {24'd0, exp_bank[1]});
    i2c_stop();
    check_eq("R8 read ack pulses total", n_rdack, 5);

    // Command only, then repeated start read
    i2c_start();
    put_byte(adr(3'b101, 1'b0), 1'b0, ak);
    put_byte(8'h02, 1'b0, ak);
    model_sel = 2'd2;
    i2c_start();
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    check_eq("R6 ack after repeated start", {31'd0, ak}, 1);
    get_byte(1'b0, rb);
    check_eq("R12 read after command-only write", {24'd0, rb}, {24'd0, exp_bank[2]});
    i2c_stop();
    check_eq("R2 released after stop", {31'd0, sda_pull}, 0);

    // Strap latching at start
    i2c_start();
    strap = 3'b010;
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    check_eq("R11 straps latched at start", {31'd0, ak}, 1);
    get_byte(1'b0, rb);
    i2c_stop();
    i2c_start();
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    check_eq("R11 new straps used after next start", {31'd0, ak}, 0);
    i2c_stop();
    strap = 3'b101;

    // SCL glitch inside a data byte
    i2c_start();
    put_byte(adr(3'b101, 1'b0), 1'b0, ak);
    put_byte(8'h03, 1'b0, ak);
    model_sel = 2'd3;
    put_data(8'h5A, 1'b1, "R10 ack with SCL glitch");
    i2c_stop();
    i2c_start();
    put_byte(adr(3'b101, 1'b1), 1'b0, ak);
    get_byte(1'b0, rb);
    check_eq("R10 glitched byte stored intact", {24'd0, rb}, {24'd0, exp_bank[3]});
    i2c_stop();

    repeat (20) @(negedge clk);
    check_eq("R12 no pending expected strobes", exp_q.size(), 0);
    check_eq("R5 strobe count", n_stb, 4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule